// File: doc/BRIEF.md
# Dual-Rate Receive Sample Slot Packer

This block builds the receive part of a frame when a single serial port carries all traffic. Frames follow the transmit sample strobe. Receive samples come on their own strobe, and that strobe may run at a different rate and phase. Between two frame starts, zero, one or two receive samples can arrive. The packer keeps them in a two-entry store. At each frame start it moves them into two receive slots and latches a two-bit status code. The code tells the far end which slots hold real samples.

The packer also serves two more slots of each frame:

- A coefficient readback slot. A rising start bit in the transmit control word triggers it. The block issues one read on a synchronous RAM port and holds the returned word in the slot.
- An echo slot. It carries either the receive control word or the eye-pattern word, as a select bit in the control word chooses.

When the mode input is high, the block is in dual-port mode. Receive traffic then travels on the second port, and the packer stays quiet.

Top module: `rx_slot_packer`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `slot_status`, `rx_slot1`, `rx_slot2`, `echo_slot`, `coef_slot`, `coef_rd_en` and `rx_overflow` are all zero. Reset also empties the sample store and clears the remembered start bit.
- R2: `slot_status` bit 0 is the first-slot flag and bit 1 is the second-slot flag. The code is 2'b00 when no sample is pending at the frame start, 2'b10 when one is pending, and 2'b11 when two are pending. The code 2'b01 never appears.
- R3: With one pending sample, that sample goes to `rx_slot2` and `rx_slot1` reads zero. With two, `rx_slot1` holds the older sample and `rx_slot2` the newer one. An unused slot reads zero.
- R4: A frame start takes every pending sample, so a sample is carried in exactly one frame. A sample whose strobe falls in the same cycle as `frame_start` is carried in the following frame. Slot outputs change only at a frame start.
- R5: If a sample arrives while two are already pending and no frame start occurs in that cycle, the oldest is discarded. `rx_overflow` then goes high and stays high until reset.
- R6: At a frame start, `tx_ctrl` bit 14 is compared with its value at the previous frame start (taken as 0 after reset). Only a 0-to-1 change raises `coef_rd_en`, for exactly one cycle, starting the cycle after the frame start. `coef_rd_addr` is then `tx_ctrl` bits [4:0]. Holding bit 14 high does not issue another read.
- R7: The RAM returns data one cycle after `coef_rd_en`. `coef_slot` takes that word on the next edge and holds it until the next read.
- R8: At each frame start, `echo_slot` latches a word in single-port mode: `eye_word` when `tx_ctrl` bit 13 is 1, and `rx_ctrl_word` when it is 0. The word then stays fixed until the next frame start.
- R9: In single-port mode (`dual_port_sel` low), `portb_ctrl_word` has no effect on any output.
- R10: In dual-port mode (`dual_port_sel` high), receive strobes are ignored, and each frame start flushes the store. The frame then shows status 2'b00 and zero in both receive slots, and `echo_slot` takes `portb_ctrl_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_port_sel | input | 1 | 0 = single-port packing, 1 = dual-port (packer quiet) |
| frame_start | input | 1 | One-cycle transmit frame strobe |
| tx_ctrl | input | 16 | Transmit control word, sampled at frame start |
| rx_strobe | input | 1 | One-cycle receive sample strobe |
| rx_sample | input | 16 | Receive sample, valid with `rx_strobe` |
| portb_ctrl_word | input | 16 | Receive control word arriving on the second port |
| rx_ctrl_word | input | 16 | Current receive control word |
| eye_word | input | 16 | Eye-pattern word |
| coef_rd_en | output | 1 | Coefficient RAM read enable |
| coef_rd_addr | output | 5 | Coefficient RAM address |
| coef_rd_data | input | 16 | Coefficient RAM read data, one cycle after enable |
| slot_status | output | 2 | Receive slot validity code |
| rx_slot1 | output | 16 | First receive slot (older sample) |
| rx_slot2 | output | 16 | Second receive slot |
| echo_slot | output | 16 | Receive-control or eye-pattern echo slot |
| coef_slot | output | 16 | Coefficient readback slot |
| rx_overflow | output | 1 | Sticky sample-loss flag |

## Verification
The sweep varies several inputs: 0 to 4 samples before each frame, a sample on the frame-start cycle or not, the echo select, the mode, and a start-bit pattern that holds high across frames.

Each corner case targets a specific mistake:

- A design that ordered the slots backwards would swap the two samples.
- A design that put a lone sample in the first slot would show code 01 or a non-zero `rx_slot1`.
- A design that dropped the newest sample instead of the oldest would show the wrong pair after three arrivals.
- A design that lost or duplicated a sample arriving with the frame strobe would show it in no frame or in two.
- A level-triggered read would raise `coef_rd_en` again while the start bit is held high.
- After a mid-run reset, a forgotten start-bit history would block the first read.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    ST_NONE  = 2'b00,
    ST_SLOT2 = 2'b10,
    ST_BOTH  = 2'b11
  } slot_status_e;

  // Validity code from the number of pending samples at frame start
  function automatic slot_status_e status_for(input logic [1:0] depth);
    case (depth)
      2'd0:    return ST_NONE;
      2'd1:    return ST_SLOT2;
      default: return ST_BOTH;
    endcase
  endfunction

  // True when the start bit went from 0 to 1 between two frames
  function automatic logic start_rise(input logic now_bit, input logic prev_bit);
    return now_bit & ~prev_bit;
  endfunction

endpackage

// File: rtl/rsp_rx_fifo.sv
module rsp_rx_fifo #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             flush,
  input  logic [SMP_W-1:0] din,
  output logic [1:0]       depth,
  output logic [SMP_W-1:0] old_q,
  output logic [SMP_W-1:0] new_q,
  output logic             ovf,
  output logic             drop_evt
);

  localparam int unsigned FULL = 2;

  logic [SMP_W-1:0] e0_q, e1_q;
  logic [1:0]       cnt_q;
  logic             ovf_q;

  assign drop_evt = push && !flush && (cnt_q == 2'(FULL));

  always_ff @(posedge clk) begin
    if (rst) begin
      e0_q  <= '0;
      e1_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush) begin
      if (push) begin
        e0_q  <= din;
        cnt_q <= 2'd1;
      end else begin
        cnt_q <= 2'd0;
      end
    end else if (push) begin
      case (cnt_q)
        2'd0: begin
          e0_q  <= din;
          cnt_q <= 2'd1;
        end
        2'd1: begin
          e1_q  <= din;
          cnt_q <= 2'd2;
        end
        default: begin
          e0_q  <= e1_q;
          e1_q  <= din;
          ovf_q <= 1'b1;
        end
      endcase
    end
  end

  assign depth = cnt_q;
  assign old_q = e0_q;
  assign new_q = e1_q;
  assign ovf   = ovf_q;

  p_depth_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 2'(FULL));

  p_flush_empties_r4: assert property (@(posedge clk) disable iff (rst)
    (flush && !push) |=> (depth == 2'd0));

  p_drop_flags_r5: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> ovf);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  p_drop_keeps_newest_r5: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> (old_q == $past(new_q)) && (new_q == $past(din)));

endmodule

// File: rtl/rsp_coef_reader.sv
module rsp_coef_reader #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              start_bit,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] slot_q,
  output logic              rise_evt
);

  import rsp_pkg::*;

  logic              prev_q;
  logic              en_q;
  logic              ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign rise_evt = frame_start && start_rise(start_bit, prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      en_q   <= 1'b0;
      ack_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (frame_start) prev_q <= start_bit;
      en_q  <= rise_evt;
      ack_q <= en_q;
      if (rise_evt) addr_q <= addr_in;
      if (ack_q) data_q <= rd_data;
    end
  end

  assign rd_en   = en_q;
  assign rd_addr = addr_q;
  assign slot_q  = data_q;

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  p_no_read_without_frame_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> !rd_en);

  p_data_capture_r7: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> (slot_q == $past(rd_data)));

  p_slot_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !ack_q |=> $stable(slot_q));

endmodule

// File: rtl/rsp_echo_mux.sv
module rsp_echo_mux #(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              dual,
  input  logic              eye_sel,
  input  logic [CTRL_W-1:0] rxc_word,
  input  logic [CTRL_W-1:0] eye_word,
  input  logic [CTRL_W-1:0] portb_word,
  output logic [CTRL_W-1:0] echo_q
);

  logic [CTRL_W-1:0] pick;
  logic [CTRL_W-1:0] hold_q;

  always_comb begin
    if (dual)         pick = portb_word;
    else if (eye_sel) pick = eye_word;
    else              pick = rxc_word;
  end

  always_ff @(posedge clk) begin
    if (rst)              hold_q <= '0;
    else if (frame_start) hold_q <= pick;
  end

  assign echo_q = hold_q;

  p_echo_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(echo_q));

  p_echo_eye_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !dual && eye_sel) |=> (echo_q == $past(eye_word)));

  p_echo_portb_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_start && dual) |=> (echo_q == $past(portb_word)));

endmodule

// File: rtl/rx_slot_packer.sv
module rx_slot_packer #(
  parameter int SMP_W       = 16,
  parameter int CTRL_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int START_BIT   = 14,
  parameter int EYE_SEL_BIT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dual_port_sel,
  input  logic              frame_start,
  input  logic [CTRL_W-1:0] tx_ctrl,
  input  logic              rx_strobe,
  input  logic [SMP_W-1:0]  rx_sample,
  input  logic [CTRL_W-1:0] portb_ctrl_word,
  input  logic [CTRL_W-1:0] rx_ctrl_word,
  input  logic [CTRL_W-1:0] eye_word,
  output logic              coef_rd_en,
  output logic [ADDR_W-1:0] coef_rd_addr,
  input  logic [SMP_W-1:0]  coef_rd_data,
  output logic [1:0]        slot_status,
  output logic [SMP_W-1:0]  rx_slot1,
  output logic [SMP_W-1:0]  rx_slot2,
  output logic [CTRL_W-1:0] echo_slot,
  output logic [SMP_W-1:0]  coef_slot,
  output logic              rx_overflow
);

  import rsp_pkg::*;

  localparam int ADDR_LSB = 0;
  localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;

  // Named internal events for the checks
  logic             push_evt;
  logic             drop_evt;
  logic             rise_evt;
  logic [1:0]       depth;
  logic [SMP_W-1:0] old_smp, new_smp;

  assign push_evt = rx_strobe && !dual_port_sel;

  rsp_rx_fifo #(.SMP_W(SMP_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push_evt),
    .flush    (frame_start),
    .din      (rx_sample),
    .depth    (depth),
    .old_q    (old_smp),
    .new_q    (new_smp),
    .ovf      (rx_overflow),
    .drop_evt (drop_evt)
  );

  rsp_coef_reader #(.ADDR_W(ADDR_W), .DATA_W(SMP_W)) u_coef (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .start_bit   (tx_ctrl[START_BIT]),
    .addr_in     (tx_ctrl[ADDR_MSB:ADDR_LSB]),
    .rd_en       (coef_rd_en),
    .rd_addr     (coef_rd_addr),
    .rd_data     (coef_rd_data),
    .slot_q      (coef_slot),
    .rise_evt    (rise_evt)
  );

  rsp_echo_mux #(.CTRL_W(CTRL_W)) u_echo (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .dual        (dual_port_sel),
    .eye_sel     (tx_ctrl[EYE_SEL_BIT]),
    .rxc_word    (rx_ctrl_word),
    .eye_word    (eye_word),
    .portb_word  (portb_ctrl_word),
    .echo_q      (echo_slot)
  );

  // Slot assignment from pending samples
  slot_status_e     st_next;
  logic [SMP_W-1:0] s1_next, s2_next;

  always_comb begin
    st_next = status_for(depth);
    s1_next = '0;
    s2_next = '0;
    if (dual_port_sel) begin
      st_next = ST_NONE;
    end else if (depth == 2'd2) begin
      s1_next = old_smp;
      s2_next = new_smp;
    end else if (depth == 2'd1) begin
      s2_next = old_smp;
    end
  end

  slot_status_e     st_q;
  logic [SMP_W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_NONE;
      s1_q <= '0;
      s2_q <= '0;
    end else if (frame_start) begin
      st_q <= st_next;
      s1_q <= s1_next;
      s2_q <= s2_next;
    end
  end

  assign slot_status = st_q;
  assign rx_slot1    = s1_q;
  assign rx_slot2    = s2_q;

  p_no_code01_r2: assert property (@(posedge clk) disable iff (rst)
    slot_status != 2'b01);

  p_lone_in_slot2_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !dual_port_sel && depth == 2'd1)
      |=> (rx_slot1 == '0) && (rx_slot2 == $past(old_smp)) && (slot_status == 2'b10));

  p_slots_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(rx_slot1) && $stable(rx_slot2) && $stable(slot_status));

  p_read_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> coef_rd_en && (coef_rd_addr == $past(tx_ctrl[ADDR_MSB:ADDR_LSB])));

  p_dual_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_start && dual_port_sel) |=> (slot_status == 2'b00) && (rx_slot1 == '0) && (rx_slot2 == '0));

endmodule

// File: tb/rx_slot_packer_tb.sv
module rx_slot_packer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dual_port_sel = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] tx_ctrl = '0;
  logic        rx_strobe = 1'b0;
  logic [15:0] rx_sample = '0;
  logic [15:0] portb_ctrl_word = '0;
  logic [15:0] rx_ctrl_word = '0;
  logic [15:0] eye_word = '0;
  logic        coef_rd_en;
  logic [4:0]  coef_rd_addr;
  logic [15:0] coef_rd_data;
  logic [1:0]  slot_status;
  logic [15:0] rx_slot1, rx_slot2, echo_slot, coef_slot;
  logic        rx_overflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  rx_slot_packer u_dut (
    .clk(clk), .rst(rst), .dual_port_sel(dual_port_sel), .frame_start(frame_start),
    .tx_ctrl(tx_ctrl), .rx_strobe(rx_strobe), .rx_sample(rx_sample),
    .portb_ctrl_word(portb_ctrl_word), .rx_ctrl_word(rx_ctrl_word), .eye_word(eye_word),
    .coef_rd_en(coef_rd_en), .coef_rd_addr(coef_rd_addr), .coef_rd_data(coef_rd_data),
    .slot_status(slot_status), .rx_slot1(rx_slot1), .rx_slot2(rx_slot2),
    .echo_slot(echo_slot), .coef_slot(coef_slot), .rx_overflow(rx_overflow)
  );

  // Coefficient RAM model: one-cycle synchronous read
  function automatic logic [15:0] ram_word(input logic [4:0] a);
    return ({3'b0, a} * 16'h0203) ^ 16'hA55A;
  endfunction

  logic [15:0] ram_q = '0;
  always @(posedge clk) if (coef_rd_en) ram_q <= ram_word(coef_rd_addr);
  assign coef_rd_data = ram_q;

  // Reference state
  int          m_cnt = 0;
  logic [15:0] m_e0 = '0, m_e1 = '0;
  bit          m_ovf = 0, m_prev = 0;
  logic [15:0] m_coef = '0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_ovf = 0; m_prev = 0; m_coef = '0;
    chk("R1 status", 16'(slot_status), 16'h0);
    chk("R1 slot1", rx_slot1, 16'h0);
    chk("R1 slot2", rx_slot2, 16'h0);
    chk("R1 echo", echo_slot, 16'h0);
    chk("R1 coef", coef_slot, 16'h0);
    chk("R1 rd_en", 16'(coef_rd_en), 16'h0);
    chk("R1 ovf", 16'(rx_overflow), 16'h0);
  endtask

  task automatic push(input logic [15:0] v);
    rx_strobe = 1'b1; rx_sample = v;
    @(negedge clk);
    rx_strobe = 1'b0;
    if (!dual_port_sel) begin
      if (m_cnt == 0)      begin m_e0 = v; m_cnt = 1; end
      else if (m_cnt == 1) begin m_e1 = v; m_cnt = 2; end
      else begin m_e0 = m_e1; m_e1 = v; m_ovf = 1; end
    end
    @(negedge clk);
  endtask

  task automatic do_frame(input logic [15:0] ctrl, input bit with_push, input logic [15:0] pv);
    logic [15:0] e_st, e_s1, e_s2, e_echo;
    bit rise;
    if (dual_port_sel || m_cnt == 0) begin e_st = 0; e_s1 = 0; e_s2 = 0; end
    else if (m_cnt == 1) begin e_st = 16'h2; e_s1 = 0; e_s2 = m_e0; end
    else begin e_st = 16'h3; e_s1 = m_e0; e_s2 = m_e1; end
    e_echo = dual_port_sel ? portb_ctrl_word : (ctrl[13] ? eye_word : rx_ctrl_word);
    rise = ctrl[14] && !m_prev;
    m_prev = ctrl[14];
    if (rise) m_coef = ram_word(ctrl[4:0]);
    frame_start = 1'b1; tx_ctrl = ctrl; rx_strobe = with_push; rx_sample = pv;
    @(negedge clk);
    frame_start = 1'b0; rx_strobe = 1'b0;
    if (!dual_port_sel && with_push) begin m_cnt = 1; m_e0 = pv; end
    else m_cnt = 0;
    chk("R2 status code", 16'(slot_status), e_st);
    chk("R3 slot1", rx_slot1, e_s1);
    chk("R3 slot2", rx_slot2, e_s2);
    chk(dual_port_sel ? "R10 echo" : "R8/R9 echo", echo_slot, e_echo);
    chk("R6 rd_en", 16'(coef_rd_en), 16'(rise));
    if (rise) chk("R6 rd_addr", 16'(coef_rd_addr), 16'(ctrl[4:0]));
    chk("R5 overflow", 16'(rx_overflow), 16'(m_ovf));
    portb_ctrl_word = ~portb_ctrl_word ^ 16'h1357;
    @(negedge clk);
    chk("R6 single pulse", 16'(coef_rd_en), 16'h0);
    @(negedge clk);
    chk("R7 coef slot", coef_slot, m_coef);
    chk("R8 echo hold", echo_slot, e_echo);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int iter = 0;
    do_reset();
    for (int md = 0; md < 2; md++) begin
      dual_port_sel = md[0];
      for (int np = 0; np < 5; np++) begin
        for (int sim = 0; sim < 2; sim++) begin
          for (int eye = 0; eye < 2; eye++) begin
            logic [15:0] ctrl;
            rx_ctrl_word = 16'h3000 + 16'(iter);
            eye_word     = 16'hE000 + 16'(iter * 3);
            for (int k = 0; k < np; k++) push(16'(iter * 16 + k + 1));
            ctrl = {1'b0, (iter % 3 != 0), eye[0], 8'h00, 5'(iter)};
            do_frame(ctrl, sim[0], 16'h8000 + 16'(iter));
            // R4: a following frame with no new arrivals
            do_frame(ctrl ^ 16'h0001, 1'b0, 16'h0);
            iter++;
          end
        end
      end
    end
    // R5: sticky overflow and drop-oldest order, then reset clears it (R1)
    dual_port_sel = 1'b0;
    push(16'h0A01); push(16'h0A02); push(16'h0A03); push(16'h0A04);
    do_frame(16'h4011, 1'b0, 16'h0);
    do_frame(16'h4012, 1'b0, 16'h0);
    chk("R5 sticky", 16'(rx_overflow), 16'h1);
    do_reset();
    // R6: start bit held before reset counts as new rise after reset
    do_frame(16'h4015, 1'b0, 16'h0);
    do_frame(16'h4016, 1'b0, 16'h0);
    do_frame(16'h0000, 1'b0, 16'h0);
    do_frame(16'h401F, 1'b0, 16'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule